// File: doc/BRIEF.md
# S/PDIF Auxiliary-Bit Serial Formatter

This block sits behind an S/PDIF receiver. It takes one decoded stereo frame at a time: two 24-bit audio words and the per-subframe channel-status, user and validity bits, plus a flag that marks the first frame of a channel-status block. It drives them out as a serial audio stream with its own frame clock and bit clock. A three-bit control register selects the format: a plain two-channel I2S frame of 64 bit clocks, or an eight-slot TDM frame of 256 bit clocks. In the TDM frame one slot carries the auxiliary bits, so a downstream processor receives channel status, user data, validity and block position together with the audio they belong to.

The outputs form two groups. The audio group has the bit clock, the frame clock and the serial data. The auxiliary group presents the same auxiliary information as parallel levels: a half-frame channel indicator, the channel-status, user and validity bits of the channel in the current half, and a block-start level. Each group has its own enable and drives low while that enable is off. New samples arrive on a valid strobe and wait in a one-frame holding stage. The block loads them at each frame boundary and repeats the last one when nothing new has arrived.

Top module: `spdif_aux_tdm_fmt`

## Requirements
- R1: After reset all control bits are 0: format is I2S, and every output of both groups is low.
- R2: Control bit 0 enables the audio group; while it is 0, `ser_bclk`, `ser_fclk` and `ser_data` are held low.
- R3: Control bit 1 enables the auxiliary group; while it is 0, `aux_lr`, `aux_cs`, `aux_user`, `aux_valid` and `aux_bstart` are held low.
- R4: Control bit 2 selects the format (0 = I2S, 1 = TDM); writes to bits 15:3 have no effect.
- R5: A TDM frame is 256 bit clocks: eight 32-bit slots, numbered 0 to 7. `ser_fclk` is high for exactly one bit clock, at bit 0 of slot 0.
- R6: In TDM, slot 0 carries the left word and slot 4 carries the right word, each MSB first in the top 24 bits of its slot with the low 8 bits zero. Slots 2, 3, 5, 6 and 7 are zero.
- R7: In TDM, slot 1 sends MSB first bit 31 = block start, 30 = right status, 29 = left status, 28 = right user, 27 = left user, 26 = right validity, 25 = left validity. Bits 24:0 are zero.
- R8: An I2S frame is 64 bit clocks. `ser_fclk` is low for the 32 left bits and high for the 32 right bits. The 24-bit word MSB follows each frame-clock edge by one bit clock, and all remaining bits are zero.
- R9: `ser_data` and `ser_fclk` change only on a falling edge of the bit clock.
- R10: The block-start bit is 1 for the frame flagged first and the 15 frames that follow it, then 0 until the next flagged frame. It is 0 after reset until a flagged frame is captured.
- R11: A frame captured by `in_valid` is sent, audio and auxiliary bits together, in the next frame that begins after the capture. Without a new capture, the previous frame is repeated.
- R12: A format change written mid-frame takes effect at the next frame boundary of the format currently running.
- R13: `aux_lr` is low during the left half of the frame and high during the right half. `aux_cs`, `aux_user` and `aux_valid` show that half's channel bits, and `aux_bstart` shows the frame's block-start bit. All change only on falling bit-clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control write data (bit 0 audio enable, bit 1 aux enable, bit 2 format) |
| in_valid | input | 1 | Captures the input frame |
| in_left | input | 24 | Left audio word |
| in_right | input | 24 | Right audio word |
| in_cs_l | input | 1 | Left channel-status bit |
| in_cs_r | input | 1 | Right channel-status bit |
| in_u_l | input | 1 | Left user bit |
| in_u_r | input | 1 | Right user bit |
| in_v_l | input | 1 | Left validity bit |
| in_v_r | input | 1 | Right validity bit |
| in_blk_first | input | 1 | Frame is the first of a channel-status block |
| ser_bclk | output | 1 | Bit clock |
| ser_fclk | output | 1 | Frame clock |
| ser_data | output | 1 | Serial data |
| aux_lr | output | 1 | Channel-half indicator |
| aux_cs | output | 1 | Channel-status bit of current half |
| aux_user | output | 1 | User bit of current half |
| aux_valid | output | 1 | Validity bit of current half |
| aux_bstart | output | 1 | Block-start level |

## Verification
The hardest case to reach is a format write that lands in the middle of a running I2S frame. Only the length of the frame-clock high stretch shows whether the old frame ran to its end: the I2S right half merges with the first TDM pulse into one 33-bit run. The bench synchronises to an I2S frame start, writes TDM a few bits later, and measures that run and the gap to the next pulse. The block-start window is reached by streaming eighteen captures after a flagged one and reading the level at the start of each frame.

// File: rtl/spdif_fmt_pkg.sv
package spdif_fmt_pkg;

  localparam int AUDIO_W = 24;

  typedef enum logic {
    FMT_I2S = 1'b0,
    FMT_TDM = 1'b1
  } fmt_e;

  typedef struct packed {
    logic [AUDIO_W-1:0] left;
    logic [AUDIO_W-1:0] right;
    logic               cs_l;
    logic               cs_r;
    logic               u_l;
    logic               u_r;
    logic               v_l;
    logic               v_r;
    logic               bstart;
  } frame_s;

endpackage

// File: rtl/spdif_fmt_bclk.sv
module spdif_fmt_bclk #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic bclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] div_q, div_d;
  logic          bclk_q, bclk_d;
  logic          wrap;

  assign wrap = (div_q == DW'(HALF_DIV - 1));

  always_comb begin
    div_d  = wrap ? '0 : div_q + DW'(1);
    bclk_d = wrap ? ~bclk_q : bclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      bclk_q <= bclk_d;
    end
  end

  assign bclk_o = bclk_q;
  assign rise_o = wrap & ~bclk_q;
  assign fall_o = wrap & bclk_q;

  // R9: every falling strobe leaves the bit clock low on the next cycle
  a_r9_fall_lowers_bclk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !bclk_o);

endmodule

// File: rtl/spdif_fmt_hold.sv
module spdif_fmt_hold
  import spdif_fmt_pkg::*;
#(
  parameter int BSTART_LEN = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_i,
  input  logic               first_i,
  input  logic [AUDIO_W-1:0] left_i,
  input  logic [AUDIO_W-1:0] right_i,
  input  logic               cs_l_i,
  input  logic               cs_r_i,
  input  logic               u_l_i,
  input  logic               u_r_i,
  input  logic               v_l_i,
  input  logic               v_r_i,
  input  logic               load_i,
  output frame_s             act_o
);
  localparam int CNW = $clog2(BSTART_LEN + 1);
  localparam logic [CNW-1:0] CNT_SAT = CNW'(BSTART_LEN);

  logic [CNW-1:0] cnt_q, cnt_d;
  frame_s         pend_q, pend_d;
  frame_s         act_q, act_d;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (cap_i) begin
      if (first_i)
        cnt_d = '0;
      else if (cnt_q != CNT_SAT)
        cnt_d = cnt_q + CNW'(1);
      pend_d.left   = left_i;
      pend_d.right  = right_i;
      pend_d.cs_l   = cs_l_i;
      pend_d.cs_r   = cs_r_i;
      pend_d.u_l    = u_l_i;
      pend_d.u_r    = u_r_i;
      pend_d.v_l    = v_l_i;
      pend_d.v_r    = v_r_i;
      pend_d.bstart = (cnt_d < CNT_SAT);
    end
    act_d = load_i ? pend_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_SAT;
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign act_o = act_q;

  // R10: a flagged capture always opens the block-start window
  a_r10_first_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_i && first_i) |=> pend_q.bstart);
  // R10: frame counter never passes its saturation value
  a_r10_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_SAT);
  // R11: the sent frame only changes on a frame-boundary load
  a_r11_active_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(act_q));

endmodule

// File: rtl/spdif_fmt_ser.sv
module spdif_fmt_ser
  import spdif_fmt_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int SLOTS  = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rise_i,
  input  logic   fall_i,
  input  fmt_e   fmt_req_i,
  input  frame_s act_i,
  output logic   load_o,
  output logic   fclk_o,
  output logic   data_o,
  output logic   aux_lr_o,
  output logic   aux_cs_o,
  output logic   aux_u_o,
  output logic   aux_v_o,
  output logic   aux_bs_o
);
  localparam int PW       = $clog2(SLOT_W);
  localparam int TDM_BITS = SLOT_W * SLOTS;
  localparam int I2S_BITS = 2 * SLOT_W;
  localparam int CW       = $clog2(TDM_BITS);
  localparam int SW       = CW - PW;
  localparam int PAD      = SLOT_W - AUDIO_W;
  localparam int AUX_N    = 7;
  localparam logic [SW-1:0] SL_LEFT  = SW'(0);
  localparam logic [SW-1:0] SL_AUX   = SW'(1);
  localparam logic [SW-1:0] SL_RIGHT = SW'(SLOTS / 2);

  logic [CW-1:0]     bit_q, bit_d, last;
  fmt_e              mode_q, mode_d;
  logic              at_end, wrap;
  logic [SLOT_W-1:0] w_left, w_right, w_aux, w_sel;
  logic [PW-1:0]     ipos;
  logic [SW-1:0]     slot;
  logic              half;
  logic              fclk_q, data_q, lr_q, cs_q, u_q, v_q, bs_q;
  logic              fclk_d, data_d, lr_d, cs_d, u_d, v_d, bs_d;

  // frame length of the format currently running
  assign last   = (mode_q == FMT_TDM) ? CW'(TDM_BITS - 1) : CW'(I2S_BITS - 1);
  assign at_end = (bit_q == last);
  assign wrap   = fall_i & at_end;
  assign load_o = rise_i & at_end;

  always_comb begin
    mode_d = wrap ? fmt_req_i : mode_q;
    bit_d  = bit_q;
    if (fall_i) bit_d = at_end ? '0 : bit_q + CW'(1);
  end

  // slot words, left-justified, MSB first
  assign w_left  = {act_i.left,  {PAD{1'b0}}};
  assign w_right = {act_i.right, {PAD{1'b0}}};
  assign w_aux   = {act_i.bstart, act_i.cs_r, act_i.cs_l, act_i.u_r, act_i.u_l,
                    act_i.v_r, act_i.v_l, {(SLOT_W - AUX_N){1'b0}}};
  assign ipos    = ~bit_d[PW-1:0];
  assign slot    = bit_d[CW-1:PW];

  always_comb begin
    if (mode_d == FMT_TDM) begin
      half   = bit_d[CW-1];
      fclk_d = (bit_d == '0);
      if (slot == SL_LEFT)       w_sel = w_left;
      else if (slot == SL_RIGHT) w_sel = w_right;
      else if (slot == SL_AUX)   w_sel = w_aux;
      else                       w_sel = '0;
    end else begin
      half   = bit_d[PW];
      fclk_d = half;
      // one bit clock of delay after each frame-clock edge
      w_sel  = half ? (w_right >> 1) : (w_left >> 1);
    end
    data_d = w_sel[ipos];
    lr_d   = half;
    cs_d   = half ? act_i.cs_r : act_i.cs_l;
    u_d    = half ? act_i.u_r  : act_i.u_l;
    v_d    = half ? act_i.v_r  : act_i.v_l;
    bs_d   = act_i.bstart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= CW'(I2S_BITS - 1);
      mode_q <= FMT_I2S;
    end else begin
      bit_q  <= bit_d;
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fclk_q <= 1'b0;
      data_q <= 1'b0;
      lr_q   <= 1'b0;
      cs_q   <= 1'b0;
      u_q    <= 1'b0;
      v_q    <= 1'b0;
      bs_q   <= 1'b0;
    end else if (fall_i) begin
      fclk_q <= fclk_d;
      data_q <= data_d;
      lr_q   <= lr_d;
      cs_q   <= cs_d;
      u_q    <= u_d;
      v_q    <= v_d;
      bs_q   <= bs_d;
    end
  end

  assign fclk_o   = fclk_q;
  assign data_o   = data_q;
  assign aux_lr_o = lr_q;
  assign aux_cs_o = cs_q;
  assign aux_u_o  = u_q;
  assign aux_v_o  = v_q;
  assign aux_bs_o = bs_q;

  // R9: frame clock and data move only with a falling bit-clock strobe
  a_r9_fclk_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_i |=> $stable(fclk_q));
  a_r9_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_i |=> $stable(data_q));
  // R12: running format only changes at the last bit of a frame
  a_r12_mode_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_i && at_end) |=> $stable(mode_q));
  // R5: TDM frame pulse lasts a single bit clock
  a_r5_tdm_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == FMT_TDM && fclk_q && fall_i && !at_end) |=> !fclk_q);
  // R7: unused tail of the auxiliary slot stays zero
  a_r7_aux_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == FMT_TDM && bit_q[CW-1:PW] == SL_AUX && bit_q[PW-1:0] >= PW'(AUX_N))
      |-> !data_q);

endmodule

// File: rtl/spdif_aux_tdm_fmt.sv
module spdif_aux_tdm_fmt
  import spdif_fmt_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int BSTART_LEN = 16,
  parameter int SLOT_W     = 32,
  parameter int SLOTS      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [15:0]        cfg_wdata,
  input  logic               in_valid,
  input  logic [AUDIO_W-1:0] in_left,
  input  logic [AUDIO_W-1:0] in_right,
  input  logic               in_cs_l,
  input  logic               in_cs_r,
  input  logic               in_u_l,
  input  logic               in_u_r,
  input  logic               in_v_l,
  input  logic               in_v_r,
  input  logic               in_blk_first,
  output logic               ser_bclk,
  output logic               ser_fclk,
  output logic               ser_data,
  output logic               aux_lr,
  output logic               aux_cs,
  output logic               aux_user,
  output logic               aux_valid,
  output logic               aux_bstart
);
  localparam int CFG_BITS = 3;

  logic [CFG_BITS-1:0] cfg_q, cfg_d;
  logic                en_audio, en_aux;
  fmt_e                fmt_req;
  logic                bclk, rise, fall, load;
  frame_s              act;
  logic                fclk_i, data_i, lr_i, cs_i, u_i, v_i, bs_i;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = cfg_wdata[CFG_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign en_audio = cfg_q[0];
  assign en_aux   = cfg_q[1];
  assign fmt_req  = fmt_e'(cfg_q[2]);

  spdif_fmt_bclk #(.HALF_DIV(HALF_DIV)) u_bclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .bclk_o (bclk),
    .rise_o (rise),
    .fall_o (fall)
  );

  spdif_fmt_hold #(.BSTART_LEN(BSTART_LEN)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_i   (in_valid),
    .first_i (in_blk_first),
    .left_i  (in_left),
    .right_i (in_right),
    .cs_l_i  (in_cs_l),
    .cs_r_i  (in_cs_r),
    .u_l_i   (in_u_l),
    .u_r_i   (in_u_r),
    .v_l_i   (in_v_l),
    .v_r_i   (in_v_r),
    .load_i  (load),
    .act_o   (act)
  );

  spdif_fmt_ser #(.SLOT_W(SLOT_W), .SLOTS(SLOTS)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_i    (rise),
    .fall_i    (fall),
    .fmt_req_i (fmt_req),
    .act_i     (act),
    .load_o    (load),
    .fclk_o    (fclk_i),
    .data_o    (data_i),
    .aux_lr_o  (lr_i),
    .aux_cs_o  (cs_i),
    .aux_u_o   (u_i),
    .aux_v_o   (v_i),
    .aux_bs_o  (bs_i)
  );

  assign ser_bclk   = bclk   & en_audio;
  assign ser_fclk   = fclk_i & en_audio;
  assign ser_data   = data_i & en_audio;
  assign aux_lr     = lr_i   & en_aux;
  assign aux_cs     = cs_i   & en_aux;
  assign aux_user   = u_i    & en_aux;
  assign aux_valid  = v_i    & en_aux;
  assign aux_bstart = bs_i   & en_aux;

  // R4: reserved write bits never alter the stored control value
  a_r4_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[15:CFG_BITS] != '0) |=> cfg_q == $past(cfg_wdata[CFG_BITS-1:0]));
  // R2: audio group silent while disabled
  a_r2_audio_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[0] |-> !(ser_bclk || ser_fclk || ser_data));
  // R3: auxiliary group silent while disabled
  a_r3_aux_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[1] |-> !(aux_lr || aux_cs || aux_user || aux_valid || aux_bstart));

endmodule

// File: tb/spdif_aux_tdm_fmt_tb.sv
module spdif_aux_tdm_fmt_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic [23:0] in_left = '0, in_right = '0;
  logic        in_cs_l = 0, in_cs_r = 0, in_u_l = 0, in_u_r = 0, in_v_l = 0, in_v_r = 0;
  logic        in_blk_first = 1'b0;
  logic        ser_bclk, ser_fclk, ser_data;
  logic        aux_lr, aux_cs, aux_user, aux_valid, aux_bstart;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  spdif_aux_tdm_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .in_cs_l(in_cs_l), .in_cs_r(in_cs_r), .in_u_l(in_u_l), .in_u_r(in_u_r),
    .in_v_l(in_v_l), .in_v_r(in_v_r), .in_blk_first(in_blk_first),
    .ser_bclk(ser_bclk), .ser_fclk(ser_fclk), .ser_data(ser_data),
    .aux_lr(aux_lr), .aux_cs(aux_cs), .aux_user(aux_user),
    .aux_valid(aux_valid), .aux_bstart(aux_bstart)
  );

  // ---------------- rising-edge monitor and R9 watcher ----------------
  event ev_rise;
  logic rf_cur = 0, rf_prev = 0;
  logic pb = 0, pf = 0, pd = 0;
  bit   mon_en = 0;
  int   edge_viol = 0;

  always @(negedge clk) begin
    if (mon_en && (ser_fclk !== pf || ser_data !== pd) && !(pb && !ser_bclk))
      edge_viol++;
    if (ser_bclk && !pb) begin
      rf_prev = rf_cur;
      rf_cur  = ser_fclk;
      pb = ser_bclk; pf = ser_fclk; pd = ser_data;
      ->ev_rise;
    end else begin
      pb = ser_bclk; pf = ser_fclk; pd = ser_data;
    end
  end

  // ---------------- model state ----------------
  logic [23:0] m_L = '0, m_R = '0;
  logic [5:0]  m_a6 = '0;
  int          m_cnt = 16;
  logic        m_bs = 1'b0;

  logic [255:0] cap_d, cap_f, cap_lr, cap_cs, cap_u, cap_v, cap_bs;

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic send(input logic [23:0] l, input logic [23:0] r,
                      input logic [5:0] a6, input bit first);
    @(negedge clk);
    in_left = l; in_right = r;
    in_cs_r = a6[5]; in_cs_l = a6[4]; in_u_r = a6[3];
    in_u_l = a6[2];  in_v_r = a6[1];  in_v_l = a6[0];
    in_blk_first = first; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_blk_first = 1'b0;
    if (first) m_cnt = 0;
    else if (m_cnt < 16) m_cnt++;
    m_bs = (m_cnt < 16);
    m_L = l; m_R = r; m_a6 = a6;
  endtask

  task automatic wait_start(input bit tdm);
    do @(ev_rise);
    while (!(tdm ? (rf_cur && !rf_prev) : (!rf_cur && rf_prev)));
  endtask

  task automatic capture(input bit tdm);
    int n;
    n = tdm ? 256 : 64;
    cap_d = '0; cap_f = '0; cap_lr = '0; cap_cs = '0;
    cap_u = '0; cap_v = '0; cap_bs = '0;
    wait_start(tdm);
    for (int b = 0; b < n; b++) begin
      if (b > 0) @(ev_rise);
      cap_d[b] = ser_data;  cap_f[b] = ser_fclk;  cap_lr[b] = aux_lr;
      cap_cs[b] = aux_cs;   cap_u[b] = aux_user;  cap_v[b] = aux_valid;
      cap_bs[b] = aux_bstart;
    end
  endtask

  // expected frame from the requirements
  task automatic check_frame(input bit tdm, input string tag);
    logic [255:0] ed, ef, elr, ecs, eu, ev, ebs;
    logic [6:0]   a7;
    int n;
    a7 = {m_bs, m_a6};
    n  = tdm ? 256 : 64;
    ed = '0; ef = '0; elr = '0; ecs = '0; eu = '0; ev = '0; ebs = '0;
    for (int b = 0; b < n; b++) begin
      int  slot, p;
      bit  half;
      slot = b / 32; p = b % 32;
      half = tdm ? (b >= 128) : (b >= 32);
      if (tdm) begin
        ef[b] = (b == 0);
        if (slot == 0 && p < 24) ed[b] = m_L[23-p];
        if (slot == 4 && p < 24) ed[b] = m_R[23-p];
        if (slot == 1 && p < 7)  ed[b] = a7[6-p];
      end else begin
        ef[b] = half;
        if (p >= 1 && p <= 24) ed[b] = half ? m_R[24-p] : m_L[24-p];
      end
      elr[b] = half;
      ecs[b] = half ? m_a6[5] : m_a6[4];
      eu[b]  = half ? m_a6[3] : m_a6[2];
      ev[b]  = half ? m_a6[1] : m_a6[0];
      ebs[b] = m_bs;
    end
    chk(cap_d == ed, {tag, tdm ? " R6 R7 data" : " R8 data"}, cap_d, ed);
    chk(cap_f == ef, {tag, tdm ? " R5 fclk" : " R8 fclk"}, cap_f, ef);
    chk(cap_lr == elr && cap_cs == ecs && cap_u == eu && cap_v == ev && cap_bs == ebs,
        {tag, " R13 aux"}, cap_cs ^ ecs ^ cap_u ^ eu ^ cap_v ^ ev, cap_lr ^ elr ^ cap_bs ^ ebs);
  endtask

  // count high samples on each group over ncyc clocks
  task automatic observe(input int ncyc, output int hi_audio, output int hi_aux);
    hi_audio = 0; hi_aux = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (ser_bclk || ser_fclk || ser_data) hi_audio++;
      if (aux_lr || aux_cs || aux_user || aux_valid || aux_bstart) hi_aux++;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    int ha, hx;
    observe(300, ha, hx);
    chk(ha == 0, "R1 audio group low after reset", ha, 0);
    chk(hx == 0, "R1 aux group low after reset", hx, 0);
  endtask

  task automatic t_i2s;
    write_cfg(16'h0003);
    wait_start(0);
    wait_start(0);
    send(24'hA5C3F1, 24'h3C5A0F, 6'b100110, 0);
    mon_en = 1;
    capture(0);
    check_frame(0, "R11 fresh I2S");
    capture(0);
    check_frame(0, "R11 repeat I2S");
    wait_start(0);
    send(24'h800001, 24'hFFFFFF, 6'b011001, 0);
    capture(0);
    check_frame(0, "R8 second pattern");
    mon_en = 0;
  endtask

  task automatic t_tdm;
    write_cfg(16'h0007);
    wait_start(1);
    wait_start(1);
    send(24'h123456, 24'hFEDCBA, 6'b101010, 1);
    mon_en = 1;
    capture(1);
    check_frame(1, "R11 TDM first");
    wait_start(1);
    send(24'h00FF00, 24'h7F0081, 6'b010101, 0);
    capture(1);
    check_frame(1, "R10 TDM second");
    mon_en = 0;
    chk(edge_viol == 0, "R9 outputs moved off falling edge", edge_viol, 0);
  endtask

  task automatic t_mode_switch;
    int n1, run, gap;
    write_cfg(16'h0003);
    wait_start(0);
    wait_start(0);
    write_cfg(16'h0007);
    n1 = 0;
    while (!rf_cur) begin @(ev_rise); n1++; end
    run = 0;
    while (rf_cur) begin @(ev_rise); run++; end
    gap = 0;
    while (!rf_cur) begin @(ev_rise); gap++; end
    chk(n1 == 32, "R12 I2S frame continued after write", n1, 32);
    chk(run == 33, "R12 switch at frame boundary", run, 33);
    chk(gap == 255, "R5 TDM frame length", gap, 255);
  endtask

  task automatic t_enables;
    int ha, hx;
    write_cfg(16'h0005);
    observe(2200, ha, hx);
    chk(hx == 0, "R3 aux group held low", hx, 0);
    chk(ha > 0, "R2 audio group active", ha, 1);
    write_cfg(16'h0006);
    observe(2200, ha, hx);
    chk(ha == 0, "R2 audio group held low", ha, 0);
    chk(hx > 0, "R3 aux group active", hx, 1);
  endtask

  task automatic t_reserved;
    int run;
    write_cfg(16'hFFFB);
    wait_start(0);
    wait_start(0);
    run = 0;
    @(ev_rise);
    while (!rf_cur) @(ev_rise);
    while (rf_cur) begin @(ev_rise); run++; end
    chk(run == 32, "R4 reserved bits ignored, I2S half length", run, 32);
  endtask

  task automatic t_block;
    for (int k = 0; k < 18; k++) begin
      wait_start(0);
      send(24'h000100 + k, 24'h000200 + k, 6'b000000, k == 0);
      capture(0);
      chk(cap_bs[0] == (k < 16), $sformatf("R10 block start frame %0d", k),
          cap_bs[0], (k < 16));
    end
    check_frame(0, "R10 window closed");
  endtask

  // ---------------- main ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_i2s();
    t_tdm();
    t_mode_switch();
    t_enables();
    t_reserved();
    t_block();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule